// File: doc/BRIEF.md
# Dual-Port Memory Lock Arbiter

This block decides which of two masters may use a shared memory array: a local processor port or a backplane port. Each port raises a request and drives a cycle strobe for the duration of its access. The arbiter returns a registered one-hot grant. A port that has asked and not been served sees its wait line raised.

An indivisible sequence from the backplane must reach memory without the local processor slipping in between. The arbiter therefore holds its backplane grant for as long as the backplane cycle strobe stays high, which covers a read-modify-write on one address. If the lock-on-busy option is enabled, the backplane bus-busy line also keeps the grant, which covers atomic sequences that toggle the strobe between several addresses.

A backplane master that releases only on request can leave busy asserted long after its sequence has finished. For that case, an idle counter drops the busy-based hold after a programmable number of clocks with no backplane strobe. The hold from the strobe itself never times out. When both ports ask at once, they take turns.

Top module: `dpm_lock_arb`

## Requirements
- R1: During and directly after a synchronous reset, `grant` is 2'b00 and both wait outputs are low. The first simultaneous request after reset goes to the local port.
- R2: `grant` is one-hot or zero. Bit 0 means local and bit 1 means backplane. From idle, a lone request sampled at a clock edge is granted at that edge.
- R3: When both ports request in the same idle cycle, the grant goes to the port that did not receive the most recent grant.
- R4: A granted port keeps its grant while its request or its strobe is high. The other port gets no grant during that time.
- R5: The backplane grant is held for every cycle in which `bp_strobe` is high, whatever the state of busy, the enable input or the idle counter.
- R6: Suppose `busy_lock_en` is 1, `bp_busy` is 1, and backplane request and strobe have both dropped. The backplane grant then stays high for exactly `idle_limit` further cycles before it is released.
- R7: When `busy_lock_en` is 0, `bp_busy` has no effect. The backplane grant falls at the first edge where backplane request and strobe are both low.
- R8: When a grant is released, `grant` reads 2'b00 for exactly one cycle. Only after that cycle can any port be granted again.
- R9: A requesting port that is not granted has its wait output high one clock after its request is sampled. The wait output stays high until that port is granted, and is low whenever the port holds the grant.
- R10: A backplane strobe pulse during a busy-held lock restarts the idle count. The `idle_limit` cycles are counted from the last falling strobe.
- R11: With `idle_limit` at 0, a busy-held lock ends at the same edge as it would with no busy lock at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_lock_en | input | 1 | Let backplane busy extend the backplane lock |
| idle_limit | input | CNT_W | Strobe-idle clocks after which the busy hold expires |
| loc_req | input | 1 | Local port request |
| loc_strobe | input | 1 | Local port cycle strobe |
| bp_req | input | 1 | Backplane port request |
| bp_strobe | input | 1 | Backplane address strobe |
| bp_busy | input | 1 | Backplane bus-busy line |
| grant | output | 2 | One-hot grant, bit 0 local, bit 1 backplane |
| loc_wait | output | 1 | Local port must stall |
| bp_wait | output | 1 | Backplane port must stall |

## Verification
The bound checker evaluates the following on every clock:
- the grant is never other than one-hot;
- a grant never passes directly from one port to the other;
- a held strobe or request never loses its grant;
- a granted port never sees its own wait;
- a loser under a held lock is told to wait;
- with lock-on-busy disabled, release happens at once.

Some properties can only be shown by the bench's scenarios:
- the turn-taking order between tied requests;
- the exact length of the busy-held window;
- the restart of that window by a strobe pulse;
- the behaviour with a zero limit.

These need counted sequences over many cycles.

// File: rtl/dpm_arb_pkg.sv
package dpm_arb_pkg;
  // State encoding doubles as the registered one-hot grant.
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_LOC  = 2'b01,
    ST_BP   = 2'b10
  } arb_st_t;
endpackage

// File: rtl/dpm_rr_pick.sv
module dpm_rr_pick (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic loc_req,
  input  logic bp_req,
  output logic pick_loc,
  output logic pick_bp
);
  // 1: local wins the next tie; after each grant the other side is favoured
  logic pref_loc;

  always_comb begin
    pick_loc = loc_req & (~bp_req | pref_loc);
    pick_bp  = bp_req & (~loc_req | ~pref_loc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pref_loc <= 1'b1;
    end else if (take) begin
      if (pick_loc)     pref_loc <= 1'b0;
      else if (pick_bp) pref_loc <= 1'b1;
    end
  end
endmodule

// File: rtl/dpm_busy_idle_timer.sv
module dpm_busy_idle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             strobe,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] idle_cnt;

  // Counts clocks spent owning the port with the strobe low; saturates.
  always_ff @(posedge clk) begin
    if (rst || !run || strobe) begin
      idle_cnt <= '0;
    end else if (idle_cnt != CNT_MAX) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign expired = (idle_cnt >= limit);
endmodule

// File: rtl/dpm_lock_arb.sv
module dpm_lock_arb #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_lock_en,
  input  logic [CNT_W-1:0] idle_limit,
  input  logic             loc_req,
  input  logic             loc_strobe,
  input  logic             bp_req,
  input  logic             bp_strobe,
  input  logic             bp_busy,
  output logic [1:0]       grant,
  output logic             loc_wait,
  output logic             bp_wait
);
  import dpm_arb_pkg::*;

  arb_st_t state_q, state_d;
  logic    pick_loc, pick_bp;
  logic    busy_expired;
  logic    busy_hold, loc_active, bp_active;

  dpm_rr_pick u_pick (
    .clk      (clk),
    .rst      (rst),
    .take     (state_q == ST_IDLE),
    .loc_req  (loc_req),
    .bp_req   (bp_req),
    .pick_loc (pick_loc),
    .pick_bp  (pick_bp)
  );

  dpm_busy_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_BP),
    .strobe  (bp_strobe),
    .limit   (idle_limit),
    .expired (busy_expired)
  );

  always_comb begin
    busy_hold  = busy_lock_en & bp_busy & ~busy_expired;
    loc_active = loc_req | loc_strobe;
    bp_active  = bp_req | bp_strobe | busy_hold;
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pick_loc)     state_d = ST_LOC;
        else if (pick_bp) state_d = ST_BP;
      end
      ST_LOC:  if (!loc_active) state_d = ST_IDLE;
      ST_BP:   if (!bp_active)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      loc_wait <= 1'b0;
      bp_wait  <= 1'b0;
    end else begin
      state_q  <= state_d;
      loc_wait <= loc_req & (state_d != ST_LOC);
      bp_wait  <= bp_req & (state_d != ST_BP);
    end
  end

  assign grant = state_q;
endmodule

// File: rtl/dpm_lock_arb_chk.sv
module dpm_lock_arb_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy_lock_en,
  input logic       loc_req,
  input logic       loc_strobe,
  input logic       bp_req,
  input logic       bp_strobe,
  input logic [1:0] grant,
  input logic       loc_wait,
  input logic       bp_wait
);
  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  a_r2_grant_from_req: assert property (@(posedge clk) disable iff (rst)
    $rose(grant[0]) |-> $past(loc_req));

  a_r8_gap_after_loc: assert property (@(posedge clk) disable iff (rst)
    $past(grant[0]) |-> !grant[1]);

  a_r8_gap_after_bp: assert property (@(posedge clk) disable iff (rst)
    $past(grant[1]) |-> !grant[0]);

  a_r4_loc_hold: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && (loc_req || loc_strobe)) |=> grant[0]);

  a_r5_strobe_lock: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && bp_strobe) |=> grant[1]);

  a_r7_no_busy_lock: assert property (@(posedge clk) disable iff (rst)
    (!busy_lock_en && grant[1] && !bp_req && !bp_strobe) |=> !grant[1]);

  a_r9_loser_waits: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && bp_strobe && loc_req) |=> loc_wait);

  a_r9_owner_no_wait: assert property (@(posedge clk) disable iff (rst)
    !(grant[0] && loc_wait) && !(grant[1] && bp_wait));
endmodule

bind dpm_lock_arb dpm_lock_arb_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy_lock_en (busy_lock_en),
  .loc_req      (loc_req),
  .loc_strobe   (loc_strobe),
  .bp_req       (bp_req),
  .bp_strobe    (bp_strobe),
  .grant        (grant),
  .loc_wait     (loc_wait),
  .bp_wait      (bp_wait)
);

// File: tb/dpm_lock_arb_bench.sv
`timescale 1ns/1ps
module dpm_lock_arb_bench;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             busy_lock_en = 1'b1;
  logic [CNT_W-1:0] idle_limit = 8'd2;
  logic             loc_req = 0, loc_strobe = 0, bp_req = 0, bp_strobe = 0, bp_busy = 0;
  logic [1:0]       grant;
  logic             loc_wait, bp_wait;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  dpm_lock_arb #(.CNT_W(CNT_W)) u_dpm_lock_arb (
    .clk(clk), .rst(rst), .busy_lock_en(busy_lock_en), .idle_limit(idle_limit),
    .loc_req(loc_req), .loc_strobe(loc_strobe), .bp_req(bp_req),
    .bp_strobe(bp_strobe), .bp_busy(bp_busy),
    .grant(grant), .loc_wait(loc_wait), .bp_wait(bp_wait)
  );

  // Vector: {lr, ls, br, bs, busy, grant[1:0], loc_wait, bp_wait}
  // limit 2, lock-on-busy on; expectations sampled one edge after drive.
  localparam logic [8:0] VEC [17] = '{
    9'b00000_0000, // R1 idle
    9'b10100_0101, // R3 tie, local first; R9 bp waits
    9'b11100_0101, // R4 local holds
    9'b00100_0001, // R8 gap cycle
    9'b00100_1000, // R2 lone bp granted
    9'b10110_1010, // R5 strobe lock, R9 local waits
    9'b10001_1010, // R6 busy hold 1
    9'b10001_1010, // R6 busy hold 2
    9'b10001_0010, // R6 expired, R8 gap
    9'b10001_0100, // R2 local granted
    9'b00000_0000, // R8 release
    9'b10100_1010, // R3 tie to bp (local served last)
    9'b10000_0010, // release, local still waiting
    9'b10100_0101, // R3 tie to local
    9'b00100_0001, // release
    9'b00100_1000, // bp granted
    9'b00000_0000  // release
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [4:0] v);
    {loc_req, loc_strobe, bp_req, bp_strobe, bp_busy} = v;
  endtask

  // Grant the backplane with its strobe up, from idle.
  task automatic take_bp();
    drive(5'b00110);
    step();
  endtask

  // Drop backplane req/strobe, keep busy; count samples with bp grant.
  task automatic count_hold(output int held);
    held = 0;
    drive(5'b00001);
    for (int i = 0; i < 300; i++) begin
      step();
      if (grant[1]) held++;
      else break;
    end
  endtask

  task automatic settle();
    drive(5'b00000);
    step();
    step();
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int held;
    drive(5'b10100);
    @(negedge clk);
    step();
    check("R1 reset outputs", {grant, loc_wait, bp_wait}, 4'b0000);
    drive(5'b00000);
    rst = 1'b0;

    for (int k = 0; k < 17; k++) begin
      drive(VEC[k][8:4]);
      step();
      check($sformatf("vector %0d", k), {grant, loc_wait, bp_wait}, VEC[k][3:0]);
    end

    // R7: busy ignored when lock-on-busy disabled
    busy_lock_en = 1'b0; idle_limit = 8'd5;
    take_bp();
    count_hold(held);
    check("R7 busy ignored", held[3:0], 4'd0);
    settle();

    // R6: busy hold lasts exactly idle_limit cycles
    busy_lock_en = 1'b1; idle_limit = 8'd5;
    take_bp();
    count_hold(held);
    check("R6 hold length 5", held[3:0], 4'd5);
    settle();

    // R11: zero limit behaves like no busy lock
    idle_limit = 8'd0;
    take_bp();
    count_hold(held);
    check("R11 zero limit", held[3:0], 4'd0);
    settle();

    // R10: strobe pulse restarts the idle count
    idle_limit = 8'd4;
    take_bp();
    drive(5'b00001); step(); step();
    drive(5'b00011); step();
    count_hold(held);
    check("R10 restart count", held[3:0], 4'd4);
    settle();

    // R5: strobe held long past the limit keeps the grant; local waits
    idle_limit = 8'd2;
    take_bp();
    held = 0;
    drive(5'b10011);
    for (int i = 0; i < 40; i++) begin
      step();
      if (grant[1] && loc_wait) held++;
    end
    check("R5 strobe lock 40 cycles", {3'b000, held == 40}, 4'd1);
    // R9: local granted after one idle cycle
    drive(5'b10000);
    step();
    check("R8 gap before local", {grant, loc_wait, bp_wait}, 4'b0010);
    step();
    check("R9 local granted wait low", {grant, loc_wait, bp_wait}, 4'b0100);
    settle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule